// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host bridge function. Software reaches it through a byte-wide request port. Each request carries a function number, an 8-bit register offset, write data and a write/read select. Every byte has its own fixed rule for writes. A byte may be fully writable, partly writable under a bit mask, read-only, or hold write-one-to-clear status bits. The rule is set at elaboration and cannot be changed at run time.

Reads return the stored byte one cycle after the request, together with a one-cycle valid strobe. Only function 0 exists. A read of any other function returns all ones, and a write to any other function is dropped. The identification bytes and the revision byte come from parameters and are loaded at reset, along with a fixed set of default values. The high status byte also has a reset value parameter, so that its clearable bits can start set.

Top module: `hbcfg_regfile`

## Requirements
- R1: After reset, function 0 reads back the following values: 0x04 = 0x07, 0x06 = 0xA0, 0x07 = STAT_HI_INIT (default 0x02), 0x0B = 0x06, 0x58 = 0x40, 0x59 = 0x05, each of 0x5A to 0x5F = 0x01, and 0x64 = 0xAB. Every offset not covered here or in R2 reads 0x00.
- R2: The identification bytes reset from parameters: 0x00 = VENDOR_ID[7:0], 0x01 = VENDOR_ID[15:8], 0x02 = DEVICE_ID[7:0], 0x03 = DEVICE_ID[15:8], and 0x08 = REV_ID. Writes never change them.
- R3: Writes to offsets 0x09, 0x0A, 0x0B, 0x0E and 0x0F are ignored, as are writes to the R2 bytes.
- R4: At offset 0x04 only bit 6 takes the written value. At offset 0x05 only bits 1:0 take the written value. All other bits of these two bytes keep their value.
- R5: At offset 0x07, bits 7, 5 and 4 are write-one-to-clear: writing 1 clears the bit and writing 0 leaves it. A write never sets these bits, and the other bits of the byte never change.
- R6: The following bytes accept only the bits set in their mask, and keep every other bit: 0x65 mask 0xFD, 0x66 mask 0xAF, 0x68 mask 0x08, 0x6B mask 0xC4, 0x6C mask 0xEF, 0x70 mask 0xE3, 0x71 mask 0xDF, 0x73 mask 0xEF, 0x76 mask 0xB0.
- R7: Every offset not named in R2 to R6 is fully writable. This includes 0x06, 0x54 and 0x64.
- R8: A read request with a nonzero function number returns 0xFF. A write request with a nonzero function number changes no byte.
- R9: A read request (req_valid = 1, req_write = 0) sampled at a clock edge raises rd_valid for exactly the following cycle, with the data on rd_data. rd_valid stays low after reset, and after write requests or idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_func | input | FUNC_W | Function number; only 0 is implemented |
| req_offset | input | ADDR_W | Register byte offset |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | Read data strobe, one cycle after a read request |
| rd_data | output | 8 | Read data |

## Verification
A wrong bit inside the block stays hidden until that offset is read. It then shows on rd_data in the cycle after the read request. For this reason the bench reads back all 256 offsets after the reset sweep and after each write sweep. A wrong mask or a wrong clear rule shows as a byte that differs from the value computed from the rules by the bench. A latency or strobe fault shows at once as an unexpected or missing rd_valid.

// File: rtl/hbcfg_pkg.sv
package hbcfg_pkg;

  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Bits that take the written value on a function-0 write.
  function automatic byte_t wr_mask(input logic [7:0] off);
    byte_t m;
    case (off)
      8'h00, 8'h01, 8'h02, 8'h03,
      8'h08, 8'h09, 8'h0A, 8'h0B,
      8'h0E, 8'h0F, 8'h07:          m = 8'h00;
      8'h04:                        m = 8'h40;
      8'h05:                        m = 8'h03;
      8'h65:                        m = 8'hFD;
      8'h66:                        m = 8'hAF;
      8'h68:                        m = 8'h08;
      8'h6B:                        m = 8'hC4;
      8'h6C:                        m = 8'hEF;
      8'h70:                        m = 8'hE3;
      8'h71:                        m = 8'hDF;
      8'h73:                        m = 8'hEF;
      8'h76:                        m = 8'hB0;
      default:                      m = 8'hFF;
    endcase
    return m;
  endfunction

  // Bits cleared by writing a one.
  function automatic byte_t clr_mask(input logic [7:0] off);
    return (off == 8'h07) ? 8'hB0 : 8'h00;
  endfunction

  function automatic byte_t rst_value(input logic [7:0]  off,
                                      input logic [15:0] vid,
                                      input logic [15:0] did,
                                      input logic [7:0]  rev,
                                      input logic [7:0]  stat_hi);
    byte_t v;
    case (off)
      8'h00:   v = vid[7:0];
      8'h01:   v = vid[15:8];
      8'h02:   v = did[7:0];
      8'h03:   v = did[15:8];
      8'h04:   v = 8'h07;
      8'h06:   v = 8'hA0;
      8'h07:   v = stat_hi;
      8'h08:   v = rev;
      8'h0B:   v = 8'h06;
      8'h58:   v = 8'h40;
      8'h59:   v = 8'h05;
      8'h5A, 8'h5B, 8'h5C,
      8'h5D, 8'h5E, 8'h5F: v = 8'h01;
      8'h64:   v = 8'hAB;
      default: v = 8'h00;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/hbcfg_rst_sync.sv
module hbcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/hbcfg_cell.sv
module hbcfg_cell
  import hbcfg_pkg::*;
#(
  parameter int    OFFSET  = 0,
  parameter byte_t RST_VAL = '0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  byte_t wdata,
  output byte_t q
);

  localparam byte_t WMASK = wr_mask(8'(OFFSET));
  localparam byte_t CMASK = clr_mask(8'(OFFSET));

  byte_t q_nxt;

  always_comb begin
    q_nxt = (q & ~WMASK & ~(CMASK & wdata)) | (wdata & WMASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= q_nxt;
  end

  // Bits outside the write mask and clear mask never move (R3, R4, R6)
  assert_masked_bits_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((q ^ $past(q)) & ~WMASK & ~CMASK) == '0));

  // Without a selected function-0 write the byte keeps its value (R8)
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  if (CMASK != '0) begin : g_clear
    // A one written to a clearable bit leaves it zero (R5)
    assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & $past(wdata) & CMASK) == '0));
    // A write never sets a clearable bit (R5)
    assert_w1c_never_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((q & ~$past(q) & CMASK) == '0));
  end

endmodule

// File: rtl/hbcfg_rdport.sv
module hbcfg_rdport
  import hbcfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int NREG   = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_req,
  input  logic                         func_nz,
  input  logic [ADDR_W-1:0]            offset,
  input  logic [NREG-1:0][BYTE_W-1:0]  regs,
  output logic                         rd_valid,
  output byte_t                        rd_data
);

  byte_t rd_data_nxt;

  always_comb begin
    rd_data_nxt = rd_data;
    if (rd_req) rd_data_nxt = func_nz ? 8'hFF : regs[offset];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_req) rd_data <= rd_data_nxt;
  end

  assert_rd_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);

  assert_no_stray_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);

  assert_foreign_read_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && func_nz) |=> (rd_data == 8'hFF));

endmodule

// File: rtl/hbcfg_regfile.sv
module hbcfg_regfile
  import hbcfg_pkg::*;
#(
  parameter int          ADDR_W       = 8,
  parameter int          FUNC_W       = 3,
  parameter logic [15:0] VENDOR_ID    = 16'h1D5A,
  parameter logic [15:0] DEVICE_ID    = 16'h0C40,
  parameter logic [7:0]  REV_ID       = 8'h02,
  parameter logic [7:0]  STAT_HI_INIT = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [7:0]        req_wdata,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);

  localparam int NREG = 1 << ADDR_W;

  logic                        rst_n_s;
  logic                        func_nz;
  logic                        wr_hit;
  logic                        rd_req;
  logic [NREG-1:0][BYTE_W-1:0] regs;

  hbcfg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  always_comb begin
    func_nz = (req_func != '0);
    wr_hit  = req_valid && req_write && !func_nz;
    rd_req  = req_valid && !req_write;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_byte
    logic sel_wr;
    always_comb sel_wr = wr_hit && (req_offset == ADDR_W'(i));

    hbcfg_cell #(
      .OFFSET  (i),
      .RST_VAL (rst_value(8'(i), VENDOR_ID, DEVICE_ID, REV_ID, STAT_HI_INIT))
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n_s),
      .wr_en (sel_wr),
      .wdata (req_wdata),
      .q     (regs[i])
    );
  end

  hbcfg_rdport #(.ADDR_W(ADDR_W), .NREG(NREG)) u_rdport (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_req   (rd_req),
    .func_nz  (func_nz),
    .offset   (req_offset),
    .regs     (regs),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // A write aimed at another function leaves the whole space untouched (R8)
  assert_foreign_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_write && func_nz) |=> $stable(regs));

endmodule

// File: tb/hbcfg_regfile_tb.sv
`timescale 1ns/1ps
module hbcfg_regfile_tb;

  typedef struct {
    bit         sel;
    logic [7:0] off;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_write = 1'b0;
  logic [2:0] req_func = '0;
  logic [7:0] req_offset = '0;
  logic [7:0] req_wdata = '0;
  logic       rd_valid0, rd_valid1;
  logic [7:0] rd_data0, rd_data1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  item_t      sbq[$];
  logic [7:0] m0 [256];
  logic [7:0] wm [256];
  logic [7:0] m1_stat;

  always #2.5 clk = ~clk;

  hbcfg_regfile #(
    .VENDOR_ID(16'h1D5A), .DEVICE_ID(16'h0C40), .REV_ID(8'h02), .STAT_HI_INIT(8'h02)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_func(req_func), .req_offset(req_offset), .req_wdata(req_wdata),
    .rd_valid(rd_valid0), .rd_data(rd_data0)
  );

  hbcfg_regfile #(
    .VENDOR_ID(16'h1D5A), .DEVICE_ID(16'h0C40), .REV_ID(8'h02), .STAT_HI_INIT(8'hB2)
  ) u_dut_w1c (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_func(req_func), .req_offset(req_offset), .req_wdata(req_wdata),
    .rd_valid(rd_valid1), .rd_data(rd_data1)
  );

  function automatic string tag_of(input int off);
    if (off <= 3 || off == 8) return "R2";
    if (off >= 9 && off <= 8'h0B) return "R3";
    if (off == 8'h0E || off == 8'h0F) return "R3";
    if (off == 4 || off == 5) return "R4";
    if (off == 7) return "R5";
    if (wm[off] != 8'hFF) return "R6";
    return "R7";
  endfunction

  function automatic logic [7:0] apply(input int off, input logic [7:0] old, input logic [7:0] w);
    logic [7:0] c;
    c = (off == 7) ? 8'hB0 : 8'h00;
    return (old & ~wm[off] & ~(w & c)) | (w & wm[off]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m0[i] = 8'h00;
      wm[i] = 8'hFF;
    end
    m0[0] = 8'h5A; m0[1] = 8'h1D; m0[2] = 8'h40; m0[3] = 8'h0C; m0[8] = 8'h02;
    m0[4] = 8'h07; m0[6] = 8'hA0; m0[7] = 8'h02; m0[8'h0B] = 8'h06;
    m0[8'h58] = 8'h40; m0[8'h59] = 8'h05; m0[8'h64] = 8'hAB;
    for (int i = 8'h5A; i <= 8'h5F; i++) m0[i] = 8'h01;
    for (int i = 0; i < 4; i++) wm[i] = 8'h00;
    for (int i = 8; i < 12; i++) wm[i] = 8'h00;
    wm[8'h0E] = 8'h00; wm[8'h0F] = 8'h00; wm[7] = 8'h00;
    wm[4] = 8'h40; wm[5] = 8'h03;
    wm[8'h65] = 8'hFD; wm[8'h66] = 8'hAF; wm[8'h68] = 8'h08; wm[8'h6B] = 8'hC4;
    wm[8'h6C] = 8'hEF; wm[8'h70] = 8'hE3; wm[8'h71] = 8'hDF; wm[8'h73] = 8'hEF;
    wm[8'h76] = 8'hB0;
    m1_stat = 8'hB2;
  endtask

  task automatic do_write(input logic [2:0] fn, input int off, input logic [7:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_func = fn;
    req_offset = 8'(off); req_wdata = w;
    if (fn == 3'd0) begin
      m0[off] = apply(off, m0[off], w);
      if (off == 7) m1_stat = apply(7, m1_stat, w);
    end
  endtask

  task automatic do_read(input bit sel, input logic [2:0] fn, input int off, input string tag);
    item_t it;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_func = fn;
    req_offset = 8'(off); req_wdata = 8'h00;
    it.sel = sel;
    it.off = 8'(off);
    it.tag = tag;
    if (fn != 3'd0)   it.exp = 8'hFF;
    else if (sel)     it.exp = m1_stat;
    else              it.exp = m0[off];
    sbq.push_back(it);
  endtask

  task automatic do_idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
    end
  endtask

  task automatic sweep(input logic [7:0] w);
    for (int i = 0; i < 256; i++) do_write(3'd0, i, w);
    for (int i = 0; i < 256; i++) do_read(1'b0, 3'd0, i, tag_of(i));
  endtask

  // Monitor: pops one expected item per read strobe
  always @(negedge clk) begin
    item_t      it;
    logic [7:0] got;
    if (rst_n && !done && rd_valid0) begin
      checks++;
      if (sbq.size() == 0) begin
        fails++;
        $display("FAIL R9 unexpected rd_valid: actual=1 expected=0");
      end else begin
        it  = sbq.pop_front();
        got = it.sel ? rd_data1 : rd_data0;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s dut%0d off=0x%02h: actual=0x%02h expected=0x%02h",
                   it.tag, it.sel, it.off, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: no strobe after reset
    checks++;
    if (rd_valid0 !== 1'b0) begin
      fails++;
      $display("FAIL R9 rd_valid after reset: actual=%b expected=0", rd_valid0);
    end

    // R1/R2: reset contents
    for (int i = 0; i < 256; i++)
      do_read(1'b0, 3'd0, i, (i <= 3 || i == 8) ? "R2" : "R1");

    // R5: write-one-to-clear on the instance whose status starts at 0xB2
    do_read(1'b1, 3'd0, 7, "R1");
    do_write(3'd0, 7, 8'h10);
    do_read(1'b1, 3'd0, 7, "R5");
    do_write(3'd0, 7, 8'h4D);
    do_read(1'b1, 3'd0, 7, "R5");
    do_write(3'd0, 7, 8'h00);
    do_read(1'b1, 3'd0, 7, "R5");
    do_write(3'd0, 7, 8'hFF);
    do_read(1'b1, 3'd0, 7, "R5");
    do_read(1'b0, 3'd0, 7, "R5");

    // R8: other functions
    do_write(3'd3, 8'h54, 8'h5A);
    do_read(1'b0, 3'd0, 8'h54, "R8");
    do_write(3'd1, 8'h06, 8'h11);
    do_read(1'b0, 3'd0, 8'h06, "R8");
    do_read(1'b0, 3'd1, 8'h04, "R8");
    do_read(1'b0, 3'd7, 8'h00, "R8");
    do_idle(2);

    // R3..R7: masked behaviour under several patterns
    sweep(8'hFF);
    sweep(8'h00);
    sweep(8'hA5);
    sweep(8'h5A);

    // R8 again after contents have changed
    do_write(3'd2, 8'h54, 8'hC3);
    do_read(1'b0, 3'd0, 8'h54, "R8");
    do_read(1'b0, 3'd5, 8'h54, "R8");

    do_idle(4);

    // R9: every read request got its strobe
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R9 missing strobes: actual=%0d pending expected=0", sbq.size());
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule